// File: doc/BRIEF.md
# Parallel Bit-Plane Top-W Selector

The block receives N unsigned B-bit values side by side on one wide input bus. It picks the W largest of them, or the W smallest when the minimum-search input is high. The result comes out in two forms. One is an N-bit mask that marks the winners. The other is a list of W winner indices in rank order.

Selection works as a radix search, one bit plane per clock, starting at the most significant bit. A candidate mask starts with every position set. At each plane the block takes the bitwise AND of the candidates with that plane and counts the ones. If there are enough of them, the candidates narrow to those positions. If there are too few, those positions are winners outright and the remaining quota shrinks by their count. The selection step uses no magnitude comparator.

After the last plane, all remaining candidates hold the same value. The lowest-indexed ones fill whatever quota is left. A start/busy/done handshake frames each search. A configuration with N not greater than W is refused at elaboration.

Top module: `topw_select`

## Requirements
- R1: While reset is held and on the first cycle after it, busy and done are low and sel_mask and rank_idx are all zeros.
- R2: A start sampled high while idle is accepted. busy is then high from the next cycle until done rises. done is high for exactly one cycle, B+1 clock cycles after the accepting edge, and busy is low in that cycle.
- R3: When done is high, sel_mask has exactly W bits set.
- R4: With find_min low, sel_mask bit i is set for the W largest values. Value i occupies data_in bits [i*B +: B]. Among equal values at the cut-off, lower indices win.
- R5: With find_min high, sel_mask marks the W smallest values, with the same tie rule as R4.
- R6: rank_idx slot r occupies bits [r*IW +: IW], where IW = clog2(N). Slot 0 holds the best winner. Slots run from largest to smallest value when find_min is low, and from smallest to largest when it is high. Equal values are listed in ascending index order.
- R7: start is ignored while busy is high. The result belongs to the data and mode sampled at the accepting edge.
- R8: sel_mask and rank_idx do not change from the cycle done rises until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search (accepted only when idle) |
| find_min | input | 1 | 1 = select smallest values, 0 = largest |
| data_in | input | N*B | Packed input values, value i at [i*B +: B] |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| sel_mask | output | N | Winner mask |
| rank_idx | output | W*clog2(N) | Winner indices in rank order |

## Verification
The assertions check several rules on every cycle of a search:
- Confirmed winners and live candidates never overlap.
- Confirmed winners plus the remaining quota always total W.
- done lasts one cycle, and busy only ever falls into a done cycle.
- Every completed mask holds W bits, and every rank slot names a masked index.
- The outputs hold still while the block is idle.

Which values are chosen, the tie-break by index, the rank order in both modes, the exact latency, and the discarding of a start raised mid-search can only be shown by the bench. It compares against orderings it computes on its own over swept and pseudo-random input sets.

// File: rtl/topw_pkg.sv
// Package: shared types for the top-W selector.
// Assumes nothing beyond the standard language.
package topw_pkg;

    // Control states of the search sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } topw_state_e;

endpackage

// File: rtl/topw_plane_step.sv
// Module: one bit-plane elimination step, purely combinational.
// Counts candidates whose current bit is one. If they meet the quota they
// become the new candidates; otherwise they are confirmed and the
// candidates with a zero bit carry on.
// Assumes rem never exceeds the number of live candidates.
module topw_plane_step #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [N-1:0]  cand,
    input  logic [N-1:0]  plane,
    input  logic [CW-1:0] rem,
    output logic [N-1:0]  cand_nx,
    output logic [N-1:0]  conf_add,
    output logic [CW-1:0] rem_nx
);

    logic [N-1:0]  hit;
    logic [CW-1:0] hit_cnt;

    // Population count of the candidates with a one in this plane.
    always_comb begin
        hit     = cand & plane;
        hit_cnt = '0;
        for (int i = 0; i < N; i++) begin
            hit_cnt = hit_cnt + CW'(hit[i]);
        end
    end

    // Decide between narrowing and confirming.
    always_comb begin
        if (hit_cnt >= rem) begin
            cand_nx  = hit;
            conf_add = '0;
            rem_nx   = rem;
        end else begin
            cand_nx  = cand & ~plane;
            conf_add = hit;
            rem_nx   = rem - hit_cnt;
        end
    end

endmodule

// File: rtl/topw_tie_fill.sv
// Module: picks the lowest-indexed set bits of a mask, up to a quota.
// Used after the last plane, when all remaining candidates are equal.
// Assumes the quota does not exceed the number of set bits.
module topw_tie_fill #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [N-1:0]  cand,
    input  logic [CW-1:0] quota,
    output logic [N-1:0]  take
);

    logic [CW-1:0] taken;

    // Walk upward in index order and claim candidates while quota lasts.
    always_comb begin
        take  = '0;
        taken = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (taken < quota)) begin
                take[i] = 1'b1;
                taken   = taken + CW'(1);
            end
        end
    end

endmodule

// File: rtl/topw_ranker.sv
// Module: orders the selected entries into a rank list.
// Keys are already oriented so that a larger key ranks first. Equal keys
// rank by ascending index.
// Assumes exactly W bits of sel are set.
module topw_ranker #(
    parameter int N  = 8,
    parameter int W  = 3,
    parameter int B  = 4,
    parameter int IW = 3
) (
    input  logic [N*B-1:0]  keys,
    input  logic [N-1:0]    sel,
    output logic [W*IW-1:0] idx
);

    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] place [N];

    // Place of each entry = number of selected entries ahead of it.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            place[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (sel[j] && (j != i) &&
                    ((keys[j*B +: B] > keys[i*B +: B]) ||
                     ((keys[j*B +: B] == keys[i*B +: B]) && (j < i)))) begin
                    place[i] = place[i] + CW'(1);
                end
            end
        end
    end

    // Drop each selected index into the slot given by its place.
    always_comb begin
        idx = '0;
        for (int r = 0; r < W; r++) begin
            for (int i = 0; i < N; i++) begin
                if (sel[i] && (place[i] == CW'(r))) begin
                    idx[r*IW +: IW] = IW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/topw_select.sv
// Module: top of the parallel bit-plane top-W selector.
// On an accepted start it latches the data, inverted in minimum mode. It
// then scans one bit plane per cycle from MSB to LSB, fills ties by
// lowest index, ranks the winners, and pulses done B+1 cycles after start.
// Assumes N > W, W >= 1, B >= 2.
module topw_select
    import topw_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 3,
    parameter int B = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            find_min,
    input  logic [N*B-1:0]  data_in,
    output logic            busy,
    output logic            done,
    output logic [N-1:0]    sel_mask,
    output logic [W*IW-1:0] rank_idx
);

    localparam int CW = $clog2(N + 1);
    localparam int BW = (B > 1) ? $clog2(B) : 1;

    // Configuration guard: every input would be selected.
    if (N <= W) begin : g_bad_cfg
        $error("topw_select: N must exceed W");
    end

    topw_state_e     state_q;
    logic [N*B-1:0]  key_q;
    logic [N*B-1:0]  key_in;
    logic [N-1:0]    cand_q, conf_q;
    logic [CW-1:0]   rem_q;
    logic [BW-1:0]   bit_q;
    logic [N-1:0]    sel_q;
    logic [W*IW-1:0] idx_q;
    logic            done_q;

    logic [N-1:0]    plane;
    logic [N-1:0]    cand_nx, conf_add;
    logic [CW-1:0]   rem_nx;
    logic [N-1:0]    tie_take;
    logic [N-1:0]    final_mask;
    logic [W*IW-1:0] rank_out;

    // Orient incoming data so the best value always has the largest key.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            key_in[i*B +: B] = find_min ? ~data_in[i*B +: B] : data_in[i*B +: B];
        end
    end

    // Gather the current bit plane across all entries.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            plane[i] = key_q[i*B + int'(bit_q)];
        end
    end

    topw_plane_step #(.N(N), .CW(CW)) u_step (
        .cand     (cand_q),
        .plane    (plane),
        .rem      (rem_q),
        .cand_nx  (cand_nx),
        .conf_add (conf_add),
        .rem_nx   (rem_nx)
    );

    topw_tie_fill #(.N(N), .CW(CW)) u_fill (
        .cand  (cand_q),
        .quota (rem_q),
        .take  (tie_take)
    );

    assign final_mask = conf_q | tie_take;

    topw_ranker #(.N(N), .W(W), .B(B), .IW(IW)) u_rank (
        .keys (key_q),
        .sel  (final_mask),
        .idx  (rank_out)
    );

    // Sequencer: load, scan B planes, finalize, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            key_q   <= '0;
            cand_q  <= '0;
            conf_q  <= '0;
            rem_q   <= '0;
            bit_q   <= '0;
            sel_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        key_q   <= key_in;
                        cand_q  <= '1;
                        conf_q  <= '0;
                        rem_q   <= CW'(W);
                        bit_q   <= BW'(B - 1);
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cand_q <= cand_nx;
                    conf_q <= conf_q | conf_add;
                    rem_q  <= rem_nx;
                    if (bit_q == '0) begin
                        state_q <= ST_FIN;
                    end else begin
                        bit_q <= bit_q - BW'(1);
                    end
                end
                ST_FIN: begin
                    sel_q   <= final_mask;
                    idx_q   <= rank_out;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign sel_mask = sel_q;
    assign rank_idx = idx_q;

    // Done is a single-cycle pulse.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Busy only ever ends into a done cycle.
    assert_busy_ends_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // A start raised mid-search never stretches or restarts it.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // Confirmed winners plus the remaining quota always total W.
    assert_quota_ledger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (($countones(conf_q) + int'(rem_q)) == W));

    // Confirmed winners and live candidates never overlap.
    assert_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((cand_q & conf_q) == '0));

    // A completed result carries exactly W winners.
    assert_count_w_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(sel_mask) == W));

    // Every rank slot names a selected entry.
    for (genvar r = 0; r < W; r++) begin : g_slot_chk
        assert_slot_in_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> sel_mask[rank_idx[r*IW +: IW]]);
    end

    // Results hold while idle with no start.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(sel_mask) && $stable(rank_idx)));

endmodule

// File: tb/tb_topw_select.sv
// Bench: swept and pseudo-random sets on a small configuration, with
// expected orderings computed by a direct selection in the bench.
module tb_topw_select;

    localparam int N  = 6;
    localparam int W  = 3;
    localparam int B  = 3;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            find_min = 1'b0;
    logic [N*B-1:0]  data_in = '0;
    logic            busy, done;
    logic [N-1:0]    sel_mask;
    logic [W*IW-1:0] rank_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    topw_select #(.N(N), .W(W), .B(B)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .find_min(find_min),
        .data_in(data_in), .busy(busy), .done(done),
        .sel_mask(sel_mask), .rank_idx(rank_idx)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Run one search; optionally hammer start with other data while busy (R7).
    task automatic run_set(input logic [N*B-1:0] vec, input logic mode, input bit disturb);
        int v [N];
        bit used [N];
        int order [W];
        logic [N-1:0] exp_mask;
        int lat;
        string rq;
        rq = mode ? "R5" : "R4";
        for (int i = 0; i < N; i++) begin
            v[i] = int'(vec[i*B +: B]);
            used[i] = 1'b0;
        end
        exp_mask = '0;
        for (int r = 0; r < W; r++) begin
            int best = -1;
            for (int i = 0; i < N; i++) begin
                if (!used[i]) begin
                    if (best < 0) best = i;
                    else if (mode ? (v[i] < v[best]) : (v[i] > v[best])) best = i;
                end
            end
            used[best] = 1'b1;
            order[r] = best;
            exp_mask[best] = 1'b1;
        end
        @(negedge clk);
        data_in = vec; find_min = mode; start = 1'b1;
        @(negedge clk);
        start = disturb;
        if (disturb) begin
            data_in = ~vec; find_min = ~mode;
        end
        lat = 0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            start = disturb && !done;
        end
        start = 1'b0;
        chk(lat == B + 1, "R2 latency", lat, B + 1);
        chk(busy == 1'b0, "R2 busy low at done", int'(busy), 0);
        chk($countones(sel_mask) == W, "R3 count", $countones(sel_mask), W);
        chk(sel_mask == exp_mask, disturb ? "R7 mask" : rq, int'(sel_mask), int'(exp_mask));
        for (int r = 0; r < W; r++) begin
            chk(int'(rank_idx[r*IW +: IW]) == order[r], "R6 slot",
                int'(rank_idx[r*IW +: IW]), order[r]);
        end
        @(negedge clk);
        chk(done == 1'b0, "R2 pulse width", int'(done), 0);
    endtask

    // Watchdog: a hung run is one failed check, then the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N*B-1:0] vec;
        logic [N-1:0] m0;
        logic [W*IW-1:0] k0;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk(busy == 1'b0 && done == 1'b0, "R1 flags in reset", int'({busy, done}), 0);
        chk(sel_mask == '0 && rank_idx == '0, "R1 outputs in reset", int'(sel_mask), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && sel_mask == '0, "R1 after reset", int'(sel_mask), 0);

        // All-equal sets: pure index tie-break (R4, R5)
        for (int val = 0; val < (1 << B); val++) begin
            for (int i = 0; i < N; i++) vec[i*B +: B] = B'(val);
            run_set(vec, 1'b0, 1'b0);
            run_set(vec, 1'b1, 1'b0);
        end

        // Arithmetic sweep: value k = (a*k + b) mod 2^B, both modes
        for (int a = 0; a < (1 << B); a++) begin
            for (int b = 0; b < (1 << B); b++) begin
                for (int i = 0; i < N; i++) vec[i*B +: B] = B'((a * i + b) % (1 << B));
                run_set(vec, 1'b0, 1'b0);
                run_set(vec, 1'b1, 1'b0);
            end
        end

        // Pseudo-random sets
        for (int t = 0; t < 600; t++) begin
            rng = next_rng(rng);
            vec = rng[N*B-1:0];
            run_set(vec, rng[31], 1'b0);
        end

        // R7: start held high with other data throughout the search
        for (int t = 0; t < 20; t++) begin
            rng = next_rng(rng);
            run_set(rng[N*B-1:0], rng[30], 1'b1);
        end

        // R8: results hold while idle
        rng = next_rng(rng);
        run_set(rng[N*B-1:0], 1'b0, 1'b0);
        m0 = sel_mask; k0 = rank_idx;
        data_in = ~data_in; find_min = 1'b1;
        repeat (6) @(negedge clk);
        chk(sel_mask == m0, "R8 mask hold", int'(sel_mask), int'(m0));
        chk(rank_idx == k0, "R8 rank hold", int'(rank_idx), int'(k0));
        chk(done == 1'b0, "R8 no stray done", int'(done), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule